// File: doc/BRIEF.md
# Serial converter conversion sequencer

This block is the digital control core of a single-channel, 8-bit serial sampling converter. A host drives two asynchronous wires into it: a convert-start line and a serial clock. A falling edge on the convert-start line powers up the analog section, opens an acquisition window on the external input, and then runs a conversion of fixed length timed by the system clock. An abstract successive-approximation core answers the conversion request. It presents an 8-bit code and pulses a done strobe.

When the conversion time has elapsed, the block removes analog power by itself and presents the most significant result bit on the serial output. The host then reads the code MSB first with the serial clock. A second start pulse during acquisition, or a start edge that lands during a conversion or a readout, redirects the input multiplexer to the half-supply self-test node. The result register is static, so a conversion with no done strobe leaves the previous code readable.

Top module: `adc_seq_ctrl`

## Requirements
- R1: In reset, and after it, `pwr_en` = 0, `conv_req` = 0, `mux_half` = 0 (external input) and `dout_oe` = 0 (high impedance).
- R2: From power-down, a high-to-low transition of `start_in`, seen after the two-stage synchroniser (3 clock edges), raises `pwr_en` with `mux_half` = 0. It holds acquisition for `ACQ_CYCLES` cycles and then raises `conv_req` for `CONV_CYCLES` cycles.
- R3: `start_in` held low from reset starts nothing, and a low-to-high transition starts nothing. Only a falling transition starts a conversion.
- R4: A falling `start_in` edge during acquisition sets `mux_half` = 1 and leaves the acquisition timing unchanged.
- R5: A falling `start_in` edge while `conv_req` is high aborts the conversion, keeps `pwr_en` high and restarts acquisition with `mux_half` = 1.
- R6: A falling `start_in` edge during readout, before all 8 bits have been clocked out, starts a new conversion with `mux_half` = 1. The external input is selected again only from power-down.
- R7: While `pwr_en` is high, `dout_oe` = 1 and `dout` = 0.
- R8: Serial clock edges during acquisition or conversion have no effect on the outputs or on the later readout order.
- R9: At the end of the conversion time, `pwr_en` and `conv_req` fall together and `dout` shows result bit 7. Each serial-clock falling edge that follows at least one rising edge advances to the next lower bit. This holds whether the serial clock idles low or high.
- R10: The rising edge of the 8th serial-clock pulse of a readout sets `dout_oe` = 0. Later serial-clock edges leave it low.
- R11: The result register loads `sar_result` on a `sar_done` pulse during conversion and otherwise holds. A conversion without `sar_done` reads out the previous code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Asynchronous convert-start line, active on the falling edge |
| sclk_in | input | 1 | Asynchronous serial read clock |
| sar_result | input | 8 | Code from the successive-approximation core |
| sar_done | input | 1 | One-cycle strobe: `sar_result` is valid |
| mux_half | output | 1 | Input select: 0 external input, 1 half-supply node |
| conv_req | output | 1 | Conversion request to the core |
| pwr_en | output | 1 | Analog power enable |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial data drive enable; 0 means high impedance |

## Verification
A wrong phase shows up at once on the four control outputs: an early or missing `pwr_en` or `conv_req`, or a data output that is released or driven at the wrong moment. This is visible in the first cycle after the faulty transition. A wrong bit pointer or edge count shows up only during a readout, as a bad serial code or a high-impedance release one pulse early or late. A lost half-supply flag is visible on `mux_half` during the rest of the conversion. Because of this, the bench compares every output on every cycle with a behavioural model and also rebuilds each read-back byte from the serial stream.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W = 8;
    localparam int IDX_W = $clog2(RES_W);

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic phase_powered(input phase_e p);
        return (p == PH_ACQ) || (p == PH_CONV);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync
    import adc_seq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  async_in,
    output edge_t ev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_comb begin
        ev.fall = chain[STAGES] & ~chain[STAGES-1];
        ev.rise = ~chain[STAGES] & chain[STAGES-1];
    end
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer
    import adc_seq_pkg::*;
#(
    parameter int ACQ_CYCLES  = 250,
    parameter int CONV_CYCLES = 1875
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   clear,
    output logic   expired
);
    localparam int unsigned LONGEST = max2(ACQ_CYCLES, CONV_CYCLES);
    localparam int TW = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] ACQ_LAST  = TW'(ACQ_CYCLES - 1);
    localparam logic [TW-1:0] CONV_LAST = TW'(CONV_CYCLES - 1);

    logic [TW-1:0] count;
    logic          running;
    logic [TW-1:0] last;

    always_comb begin
        running = phase_powered(phase);
        last    = (phase == PH_ACQ) ? ACQ_LAST : CONV_LAST;
        expired = running && (count == last);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  count <= '0;
        else if (running)  count <= count + 1'b1;
    end
endmodule

// File: rtl/adc_readout.sv
module adc_readout
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             active,
    input  edge_t            sck,
    input  logic [RES_W-1:0] code,
    output logic             bit_out,
    output logic             last_rise
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] rises;

    always_comb begin
        bit_out   = code[idx];
        last_rise = active && sck.rise && (rises == TOP_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            idx   <= TOP_IDX;
            rises <= '0;
        end else if (active) begin
            if (sck.fall && (rises != '0) && (idx != '0))
                idx <= idx - 1'b1;
            if (sck.rise && (rises != TOP_IDX))
                rises <= rises + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACQ_CYCLES  = 250,
    parameter int CONV_CYCLES = 1875
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic             sclk_in,
    input  logic [RES_W-1:0] sar_result,
    input  logic             sar_done,
    output logic             mux_half,
    output logic             conv_req,
    output logic             pwr_en,
    output logic             dout,
    output logic             dout_oe
);
    edge_t  cv_ev;
    edge_t  sk_ev;
    logic   cv_start;
    phase_e phase, phase_n;
    logic   half_q, half_n;
    logic   tmr_expired;
    logic   tmr_clear;
    logic   rd_bit;
    logic   rd_last;
    logic   rd_load;
    logic [RES_W-1:0] result_q;

    adc_edge_sync #(.STAGES(SYNC_STAGES)) u_cv_sync (
        .clk(clk), .rst(rst), .async_in(start_in), .ev(cv_ev)
    );

    adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sk_sync (
        .clk(clk), .rst(rst), .async_in(sclk_in), .ev(sk_ev)
    );

    assign cv_start = cv_ev.fall & ~cv_ev.rise;

    adc_phase_timer #(.ACQ_CYCLES(ACQ_CYCLES), .CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .phase(phase), .clear(tmr_clear), .expired(tmr_expired)
    );

    adc_readout u_rd (
        .clk(clk), .rst(rst), .load(rd_load), .active(phase == PH_READ),
        .sck(sk_ev), .code(result_q), .bit_out(rd_bit), .last_rise(rd_last)
    );

    // Phase sequencing; start edges take priority over timer and serial clock.
    always_comb begin
        phase_n = phase;
        half_n  = half_q;
        unique case (phase)
            PH_OFF: begin
                if (cv_start) begin
                    phase_n = PH_ACQ;
                    half_n  = 1'b0;
                end
            end
            PH_ACQ: begin
                if (cv_start)    half_n  = 1'b1;
                if (tmr_expired) phase_n = PH_CONV;
            end
            PH_CONV: begin
                if (cv_start) begin
                    phase_n = PH_ACQ;
                    half_n  = 1'b1;
                end else if (tmr_expired) begin
                    phase_n = PH_READ;
                end
            end
            PH_READ: begin
                if (cv_start) begin
                    phase_n = PH_ACQ;
                    half_n  = 1'b1;
                end else if (rd_last) begin
                    phase_n = PH_OFF;
                end
            end
            default: phase_n = PH_OFF;
        endcase
        tmr_clear = (phase_n != phase);
        rd_load   = (phase_n == PH_READ) && (phase != PH_READ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_OFF;
            half_q <= 1'b0;
        end else begin
            phase  <= phase_n;
            half_q <= half_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            result_q <= '0;
        else if ((phase == PH_CONV) && sar_done && !cv_start)
            result_q <= sar_result;
    end

    always_comb begin
        mux_half = half_q;
        pwr_en   = phase_powered(phase);
        conv_req = (phase == PH_CONV);
        dout_oe  = (phase != PH_OFF);
        dout     = (phase == PH_READ) ? rd_bit : 1'b0;
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic mux_half,
    input logic conv_req,
    input logic pwr_en,
    input logic dout,
    input logic dout_oe
);
    p_req_powered_r2: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> pwr_en);

    p_fresh_start_ext_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwr_en) && !$past(dout_oe)) |-> !mux_half);

    p_busy_drives_low_r7: assert property (@(posedge clk) disable iff (rst)
        pwr_en |-> (dout_oe && !dout));

    p_mux_held_conv_r4: assert property (@(posedge clk) disable iff (rst)
        (conv_req && $past(conv_req)) |-> $stable(mux_half));

    p_done_presents_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_req) && !pwr_en) |-> dout_oe);

    p_hiz_unpowered_r10: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> !pwr_en);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .mux_half(mux_half), .conv_req(conv_req),
    .pwr_en(pwr_en), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
    localparam int ACQ  = 12;
    localparam int CONV = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_in = 1'b0;
    logic sclk_in = 1'b0;
    logic [7:0] sar_result = 8'h00;
    logic sar_done = 1'b0;
    logic mux_half, conv_req, pwr_en, dout, dout_oe;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    // behavioural model state
    int mph = 0;            // 0 off, 1 acquire, 2 convert, 3 readout
    int mt = 0;
    int mhalf = 0;
    int midx = 7;
    int mrises = 0;
    logic [7:0] mres = 8'h00;
    int cq[3] = '{0, 0, 0};  // start line delay
    int sq[3] = '{0, 0, 0};  // serial clock delay
    bit feed = 1'b1;
    logic [7:0] feed_val = 8'h00;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.ACQ_CYCLES(ACQ), .CONV_CYCLES(CONV)) u_adc_seq_ctrl (
        .clk(clk), .rst(rst), .start_in(start_in), .sclk_in(sclk_in),
        .sar_result(sar_result), .sar_done(sar_done), .mux_half(mux_half),
        .conv_req(conv_req), .pwr_en(pwr_en), .dout(dout), .dout_oe(dout_oe)
    );

    always @(posedge clk) begin
        bit cf, sr, sf;
        cf = (cq[2] == 1) && (cq[1] == 0);
        sf = (sq[2] == 1) && (sq[1] == 0);
        sr = (sq[2] == 0) && (sq[1] == 1);
        cq[2] = cq[1]; cq[1] = cq[0]; cq[0] = start_in;
        sq[2] = sq[1]; sq[1] = sq[0]; sq[0] = sclk_in;
        if (rst) begin
            mph = 0; mt = 0; mhalf = 0; midx = 7; mrises = 0; mres = 8'h00;
            cq = '{0, 0, 0}; sq = '{0, 0, 0};
        end else begin
            case (mph)
                0: if (cf) begin mph = 1; mt = 0; mhalf = 0; end
                1: begin
                    if (cf) mhalf = 1;
                    if (mt == ACQ - 1) begin mph = 2; mt = 0; end
                    else mt++;
                end
                2: begin
                    if (cf) begin mph = 1; mt = 0; mhalf = 1; end
                    else begin
                        if (sar_done) mres = sar_result;
                        if (mt == CONV - 1) begin mph = 3; mt = 0; midx = 7; mrises = 0; end
                        else mt++;
                    end
                end
                default: begin
                    if (cf) begin mph = 1; mt = 0; mhalf = 1; end
                    else begin
                        if (sf && mrises > 0 && midx > 0) midx--;
                        if (sr) begin
                            if (mrises == 7) mph = 0;
                            else mrises++;
                        end
                    end
                end
            endcase
        end
    end

    task automatic report(string req, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) report(req, what, act, exp);
    endtask

    task automatic tick();
        int e_pwr, e_req, e_oe, e_dout;
        @(negedge clk);
        e_pwr  = (mph == 1 || mph == 2);
        e_req  = (mph == 2);
        e_oe   = (mph != 0);
        e_dout = (mph == 3) ? int'(mres[midx]) : 0;
        vectors++;
        if (!rst) begin
            if (pwr_en !== e_pwr[0])    report(cur_req, "pwr_en", pwr_en, e_pwr);
            if (conv_req !== e_req[0])  report(cur_req, "conv_req", conv_req, e_req);
            if (mux_half !== mhalf[0])  report(cur_req, "mux_half", mux_half, mhalf);
            if (dout_oe !== e_oe[0])    report(cur_req, "dout_oe", dout_oe, e_oe);
            if (dout !== e_dout[0])     report(cur_req, "dout", dout, e_dout);
        end
        sar_done   = (mph == 2) && (mt == 5) && feed;
        sar_result = feed_val;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic read_byte(bit idle_high, output logic [7:0] b);
        b = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            if (idle_high) begin
                sclk_in = 1'b0; ticks(4);
                b[i] = dout;
                sclk_in = 1'b1; ticks(4);
            end else begin
                b[i] = dout;
                sclk_in = 1'b1; ticks(4);
                sclk_in = 1'b0; ticks(4);
            end
        end
    endtask

    task automatic fall_start();
        start_in = 1'b1; ticks(4);
        start_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] got;
        ticks(4);
        cur_req = "R1";
        chk("R1", "pwr_en in reset", pwr_en, 0);
        chk("R1", "dout_oe in reset", dout_oe, 0);
        rst = 1'b0;
        ticks(2);
        chk("R1", "mux_half after reset", mux_half, 0);
        chk("R1", "conv_req after reset", conv_req, 0);

        // R3: start low from reset, then a rising edge only
        cur_req = "R3";
        ticks(20);
        chk("R3", "pwr_en with start held low", pwr_en, 0);
        start_in = 1'b1; ticks(10);
        chk("R3", "pwr_en after rising start", pwr_en, 0);

        // R2, R7, R8, R9, R10: conversion then idle-low read
        cur_req = "R2"; feed = 1; feed_val = 8'hA5;
        start_in = 1'b0; ticks(4);
        chk("R2", "pwr_en after start", pwr_en, 1);
        chk("R2", "mux_half external", mux_half, 0);
        chk("R7", "dout_oe while busy", dout_oe, 1);
        chk("R7", "dout while busy", dout, 0);
        cur_req = "R8";
        for (int k = 0; k < 3; k++) begin
            sclk_in = 1'b1; ticks(2); sclk_in = 1'b0; ticks(2);
        end
        ticks(6);
        chk("R2", "conv_req in conversion", conv_req, 1);
        ticks(19);
        cur_req = "R9";
        chk("R9", "pwr_en after completion", pwr_en, 0);
        chk("R9", "dout MSB after completion", dout, 1);
        read_byte(1'b0, got);
        chk("R9", "idle-low read byte", got, 8'hA5);
        ticks(2);
        chk("R10", "dout_oe after eighth rise", dout_oe, 0);
        sclk_in = 1'b1; ticks(4); sclk_in = 1'b0; ticks(4);
        chk("R10", "dout_oe after extra pulse", dout_oe, 0);

        // R9 idle-high read
        cur_req = "R9"; feed_val = 8'h3C;
        sclk_in = 1'b1;
        fall_start(); ticks(45);
        read_byte(1'b1, got);
        chk("R9", "idle-high read byte", got, 8'h3C);
        chk("R10", "dout_oe after idle-high read", dout_oe, 0);
        ticks(4); sclk_in = 1'b0; ticks(4);

        // R4: second pulse in acquisition
        cur_req = "R4"; feed_val = 8'h81;
        fall_start(); ticks(4);
        start_in = 1'b1; ticks(3); start_in = 1'b0;
        ticks(13);
        chk("R4", "conv_req timing kept", conv_req, 1);
        chk("R4", "mux_half after second pulse", mux_half, 1);
        ticks(25);
        read_byte(1'b0, got);
        chk("R4", "half-supply read byte", got, 8'h81);

        // R5: start edge during conversion
        cur_req = "R5"; feed_val = 8'h5A;
        fall_start(); ticks(25);
        start_in = 1'b1; ticks(3); start_in = 1'b0; ticks(4);
        chk("R5", "pwr_en after abort", pwr_en, 1);
        chk("R5", "conv_req after abort", conv_req, 0);
        chk("R5", "mux_half after abort", mux_half, 1);
        ticks(45);
        read_byte(1'b0, got);
        chk("R5", "read after restart", got, 8'h5A);

        // R6: start edge during a partial readout
        cur_req = "R6"; feed_val = 8'hC3;
        fall_start(); ticks(45);
        for (int k = 0; k < 3; k++) begin
            sclk_in = 1'b1; ticks(4); sclk_in = 1'b0; ticks(4);
        end
        feed_val = 8'h0F;
        fall_start(); ticks(4);
        chk("R6", "pwr_en after readout start", pwr_en, 1);
        chk("R6", "mux_half after readout start", mux_half, 1);
        chk("R7", "dout low after restart", dout, 0);
        ticks(45);
        read_byte(1'b0, got);
        chk("R6", "read after readout restart", got, 8'h0F);

        // R11: conversion without a done strobe keeps the old code
        cur_req = "R11"; feed = 0; feed_val = 8'hFF;
        fall_start(); ticks(45);
        read_byte(1'b0, got);
        chk("R11", "held result", got, 8'h0F);
        ticks(4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule